// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Tracker

This block keeps an approximate recency record for a single set of an N-way cache and names the way to evict next. Its state is a binary tree of N-1 direction bits. Each bit belongs to one internal node, and each leaf of the tree is one way. When the access strobe is high, every node on the route from the root down to the accessed way inverts its bit at the next clock edge.

The victim is found by walking down from the root. A node holding 0 sends the walk to its left child and a node holding 1 sends it to its right child. The leaf where the walk ends is the victim way. The walk is purely combinational from the registered tree, so the victim output follows the tree in the same cycle that the tree changes.

The way count is a power-of-two parameter and defaults to 8. Tag compare, hit and miss detection, data storage and selection among several sets are handled outside this block.

Top module: `plru_tracker`

## Requirements
- R1: While reset (rstN low, asynchronous) is active, all tree bits clear to 0, so the victim output reads way 0.
- R2: An access changes the victim output no earlier than the cycle after the access; during the access cycle itself the victim output still reflects the old tree.
- R3: The nodes use heap numbering. Node 0 is the root and node i has children 2i+1 (left) and 2i+2 (right). On an access to way w, the route from the root follows the bits of w from MSB to LSB, with 0 meaning left and 1 meaning right.
- R4: An access inverts exactly the log2(N) nodes on the route to the accessed way and leaves every other node unchanged. With 8 ways, an access to way 3 inverts nodes 0, 1 and 4; starting from reset, the victim afterwards is way 4.
- R5: A cycle with accValid low leaves every tree bit, and therefore the victim, unchanged, whatever value accWay holds.
- R6: The victim walk starts at the root and at each node moves left on 0 and right on 1. The victim index is built MSB first from the bits it reads.
- R7: The victim output is combinational from the registered tree bits and is valid in the same cycle the tree updates.
- R8: Two consecutive accesses to the same way restore the tree to the state it had before the first of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | High in a cycle where a way of the set is accessed |
| accWay | input | log2(WAYS) | Index of the accessed way |
| victimWay | output | log2(WAYS) | Way selected by walking the tree |

## Verification
The bench aims at four kinds of error. The first is a route that reads the way bits LSB first or numbers children the wrong way round; such a design inverts the wrong nodes, and its victim sequence soon departs from the expected one. The second is a design that sets bits instead of inverting them; it fails the case where the same way is accessed twice in a row and the tree should return to its earlier state. The third is a design that updates while the strobe is low, which shows up as a changed victim after idle cycles with a non-zero way on the bus. The fourth is a victim that moves during the access cycle itself, or a reset that fails to bring the victim back to way 0 from a busy state.

// File: rtl/plru_pkg.sv
package plru_pkg;

  // Strobes handed from the access decoder to the tree register
  typedef struct packed {
    logic update;   // apply the flip mask at the next edge
  } plru_strobe_t;

endpackage

// File: rtl/plru_ctrl.sv
module plru_ctrl
  import plru_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int LEVELS = $clog2(WAYS),
  localparam int NODES = WAYS - 1,
  localparam int IDX_W = LEVELS + 1
) (
  input  logic              accValid,
  input  logic [LEVELS-1:0] accWay,
  output plru_strobe_t      strobe,
  output logic [NODES-1:0]  flipMask
);

  // Node index visited at each level along the accessed way's route
  logic [IDX_W-1:0] routeNode [LEVELS+1];

  assign routeNode[0] = '0;

  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_route
    assign routeNode[lvl+1] = IDX_W'(2 * routeNode[lvl] + 1)
                            + IDX_W'(accWay[LEVELS-1-lvl]);
  end

  always_comb begin
    flipMask = '0;
    for (int n = 0; n < NODES; n++) begin
      for (int lvl = 0; lvl < LEVELS; lvl++) begin
        if (routeNode[lvl] == IDX_W'(n)) flipMask[n] = 1'b1;
      end
    end
  end

  assign strobe.update = accValid;

endmodule

// File: rtl/plru_tree_reg.sv
module plru_tree_reg
  import plru_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  plru_strobe_t     strobe,
  input  logic [NODES-1:0] flipMask,
  output logic [NODES-1:0] treeBits
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      treeBits <= '0;
    end else if (strobe.update) begin
      treeBits <= treeBits ^ flipMask;
    end
  end

endmodule

// File: rtl/plru_victim.sv
module plru_victim #(
  parameter int WAYS = 8,
  localparam int LEVELS = $clog2(WAYS),
  localparam int NODES = WAYS - 1,
  localparam int IDX_W = LEVELS + 1
) (
  input  logic [NODES-1:0]  treeBits,
  output logic [LEVELS-1:0] victimWay
);

  logic [IDX_W-1:0] walkNode [LEVELS+1];
  logic [LEVELS-1:0] stepDir;

  assign walkNode[0] = '0;

  for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_walk
    assign stepDir[lvl] = treeBits[walkNode[lvl]];
    assign walkNode[lvl+1] = IDX_W'(2 * walkNode[lvl] + 1) + IDX_W'(stepDir[lvl]);
    assign victimWay[LEVELS-1-lvl] = stepDir[lvl];
  end

endmodule

// File: rtl/plru_tracker.sv
module plru_tracker
  import plru_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int LEVELS = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [LEVELS-1:0] accWay,
  output logic [LEVELS-1:0] victimWay
);

  plru_strobe_t     strobe;
  logic [NODES-1:0] flipMask;
  logic [NODES-1:0] treeBits;

  plru_ctrl #(.WAYS(WAYS)) ctrl (
    .accValid (accValid),
    .accWay   (accWay),
    .strobe   (strobe),
    .flipMask (flipMask)
  );

  plru_tree_reg #(.WAYS(WAYS)) treeReg (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .flipMask (flipMask),
    .treeBits (treeBits)
  );

  plru_victim #(.WAYS(WAYS)) victim (
    .treeBits  (treeBits),
    .victimWay (victimWay)
  );

endmodule

// File: rtl/plru_tracker_chk.sv
module plru_tracker_chk #(
  parameter int WAYS = 8,
  localparam int LEVELS = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic [NODES-1:0]  treeBits,
  input logic [LEVELS-1:0] victimWay
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (treeBits == '0 && victimWay == '0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> $stable(treeBits)); // R5

  AST_ROUTE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> $countones(treeBits ^ $past(treeBits)) == LEVELS); // R4

  AST_ROOT_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> treeBits[0] != $past(treeBits[0])); // R3

  AST_VICTIM_MSB: assert property (@(posedge clk) disable iff (!rstN)
    victimWay[LEVELS-1] == treeBits[0]); // R6

endmodule

bind plru_tracker plru_tracker_chk #(.WAYS(WAYS)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .accValid  (accValid),
  .treeBits  (treeBits),
  .victimWay (victimWay)
);

// File: tb/plru_tracker_test.sv
module plru_tracker_test;

  localparam int WAYS = 8;
  localparam int LEVELS = $clog2(WAYS);
  localparam int NODES = WAYS - 1;
  localparam int NVEC = 8;

  // {valid, way, expected victim after the edge}
  localparam logic [6:0] VEC [NVEC] = '{
    {1'b1, 3'd3, 3'd4},
    {1'b1, 3'd4, 3'd3},
    {1'b0, 3'd6, 3'd3},
    {1'b1, 3'd0, 3'd6},
    {1'b1, 3'd6, 3'd1},
    {1'b1, 3'd6, 3'd6},
    {1'b1, 3'd7, 3'd1},
    {1'b1, 3'd1, 3'd5}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0;
  logic [LEVELS-1:0] accWay = '0;
  logic [LEVELS-1:0] victimWay;

  int testsRun = 0;
  int testsFailed = 0;
  logic [NODES-1:0] mTree;

  always #10 clk = ~clk;

  plru_tracker #(.WAYS(WAYS)) uut (
    .clk(clk), .rstN(rstN), .accValid(accValid),
    .accWay(accWay), .victimWay(victimWay)
  );

  task automatic check(input string req, input logic [LEVELS-1:0] expv);
    testsRun++;
    if (victimWay !== expv) begin
      testsFailed++;
      $display("FAIL %s: victim actual %0d expected %0d", req, victimWay, expv);
    end
  endtask

  // Bench model of the requirements (heap numbering, MSB-first route)
  function automatic logic [NODES-1:0] modelFlip(input logic [NODES-1:0] t,
                                                 input logic [LEVELS-1:0] w);
    int node = 0;
    logic [NODES-1:0] r = t;
    for (int l = 0; l < LEVELS; l++) begin
      r[node] = ~r[node];
      node = 2 * node + 1 + int'(w[LEVELS-1-l]);
    end
    return r;
  endfunction

  function automatic logic [LEVELS-1:0] modelVictim(input logic [NODES-1:0] t);
    int node = 0;
    logic [LEVELS-1:0] v = '0;
    for (int l = 0; l < LEVELS; l++) begin
      v[LEVELS-1-l] = t[node];
      node = 2 * node + 1 + int'(t[node]);
    end
    return v;
  endfunction

  task automatic step(input logic v, input logic [LEVELS-1:0] w);
    @(negedge clk);
    accValid = v;
    accWay = w;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    accValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mTree = '0;
  endtask

  initial begin
    #4_000_000;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 during reset", '0);
    rstN = 1'b1;
    mTree = '0;
    @(negedge clk);
    check("R1 after reset", '0);

    // Vector table: R3 R4 R5 R6 R8
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][6], VEC[i][5:3]);
      check(VEC[i][6] ? "R3/R4/R6/R8 table access" : "R5 table idle", VEC[i][2:0]);
    end

    // R4: way 3 from reset gives victim 4
    doReset();
    step(1'b1, 3'd3);
    check("R4 way3 example", 3'd4);

    // R2/R7: no change in the access cycle, visible right after the edge
    doReset();
    @(negedge clk);
    accValid = 1'b1;
    accWay = 3'd2;
    #2;
    check("R2 same-cycle unchanged", 3'd0);
    @(posedge clk);
    #1;
    accValid = 1'b0;
    mTree = modelFlip(mTree, 3'd2);
    check("R7 visible after edge", modelVictim(mTree));

    // R5: many idle cycles with way bits toggling
    for (int i = 0; i < 6; i++) begin
      step(1'b0, LEVELS'(i + 1));
    end
    check("R5 idle hold", modelVictim(mTree));

    // R8: double access restores state
    step(1'b1, 3'd5);
    step(1'b1, 3'd5);
    check("R8 double access restore", modelVictim(mTree));

    // Model-driven sweep: R3 R4 R6
    for (int i = 0; i < 40; i++) begin
      logic [LEVELS-1:0] w;
      logic v;
      w = LEVELS'((i * 5 + 3) % WAYS);
      v = (i % 4) != 3;
      step(v, w);
      if (v) mTree = modelFlip(mTree, w);
      check("R3/R6 sweep", modelVictim(mTree));
    end

    // R1: reset from a busy state
    doReset();
    check("R1 reset from busy", '0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule